// File: doc/BRIEF.md
# USB IN Endpoint Handshake Controller

This block picks the handshake that a USB device function answers to every non-isochronous IN token: a data packet, NAK or STALL. For each of its IN endpoints it keeps a halt flag, a NAK status bit, a STALL status bit and an interrupt bit. Endpoint 0 (by default) is the control endpoint, where a request-error strobe that arrives with the token also forces STALL.

A local host works on one endpoint at a time. It drives an endpoint number, a direction bit and a select bit. While the select bit is high and the direction bit is IN, the host can read the endpoint's status and halt flag. It can also pulse the set-halt and clear-halt command bits. When the host drops the select bit, the recorded NAK or STALL status of that endpoint is released. Until that release, the endpoint keeps its old status and answers NAK to new tokens, unless a stall condition applies. Interrupt bits are cleared by writing ones to them.

The block does not serialize packets, compute CRC, store FIFO data or decode control requests. It has no path to the transmit FIFO, so a NAK leaves the FIFO contents and pointers untouched.

Top module: `usb_in_hs_ctrl`

## Requirements
- R1: A token to an endpoint whose halt flag is set is answered with STALL (code 2'b11), on every token, until the halt flag is cleared.
- R2: A token to the control endpoint (index CTRL_EP, default 0) with `req_err` high is answered with STALL. On any other endpoint, `req_err` has no effect.
- R3: A token to an endpoint that is not halted, has no request error, has no unreleased status, and sees `tx_ready` low is answered with NAK (code 2'b10) and sets that endpoint's NAK status bit.
- R4: A STALL or NAK that is recorded sets that endpoint's STALL or NAK status bit and sets `irq[ep]` in the cycle after the token.
- R5: Writing 1 to `irq_clr[i]` clears `irq[i]` on the next edge. If a new event is recorded for the same endpoint in that cycle, the bit stays set.
- R6: `sel_nak`, `sel_stall` and `sel_halt` show the status of endpoint `sel_ep` while `sel_en`=1 and `sel_dir`=1 (IN). Otherwise they are 0.
- R7: When `sel_en` falls after a cycle with `sel_en`=1 and `sel_dir`=1, the NAK and STALL bits of the endpoint that was selected in that cycle are cleared. After that, a token with `tx_ready` high gets DATA again.
- R8: While an endpoint holds an unreleased NAK or STALL status, a new token is answered NAK if no stall condition applies. Its status bits are not overwritten, and no new interrupt is raised.
- R9: `hs_code` is registered and is valid in the cycle after the token. It is 2'b01 (DATA) when no stall or NAK condition applies, and 2'b00 in every cycle after a clock with no token. The priority order is STALL, then NAK, then DATA.
- R10: `set_halt` and `clr_halt` act on `sel_ep` only while `sel_en`=1 and `sel_dir`=1. If both are high in the same cycle, clear wins.
- R11: A synchronous reset (`rst`=1) clears all halt flags, status bits and interrupts, and sets `hs_code` to 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tok_valid | input | 1 | Decoded IN token present this cycle |
| tok_ep | input | EP_W | Endpoint number of the token |
| req_err | input | 1 | Request-error strobe for the control endpoint, sampled with the token |
| tx_ready | input | 1 | Transmit FIFO of the token's endpoint holds a packet |
| sel_en | input | 1 | Host select bit (level) |
| sel_dir | input | 1 | Host direction bit, 1 = IN |
| sel_ep | input | EP_W | Host endpoint number |
| set_halt | input | 1 | Set-halt command pulse |
| clr_halt | input | 1 | Clear-halt command pulse |
| irq_clr | input | NUM_EP | Write-one-to-clear for interrupt bits |
| hs_code | output | 2 | Handshake: 00 none, 01 DATA, 10 NAK, 11 STALL |
| sel_nak | output | 1 | NAK status of the selected endpoint |
| sel_stall | output | 1 | STALL status of the selected endpoint |
| sel_halt | output | 1 | Halt flag of the selected endpoint |
| irq | output | NUM_EP | Per-endpoint interrupt bits |
| irq_any | output | 1 | OR of all interrupt bits |

## Verification
A wrong halt flag or a stuck status bit shows up at the ports one clock after the next token to that endpoint. It appears as an unexpected code on `hs_code`, or as an interrupt that rises or fails to rise. A selection read shows it in the same cycle. A lost release shows up as NAK answers where DATA was due, starting at the first token after the falling select edge.

The reference model tracks every endpoint's flags. It compares `hs_code`, `irq`, `irq_any` and the three selection outputs on every clock. A corrupted state therefore surfaces within one cycle of being observable. Directed sequences target the priority between stall and hold-off, a set and clear of halt in the same cycle, and an interrupt set and clear in the same cycle.

// File: rtl/usb_in_hs_pkg.sv
package usb_in_hs_pkg;
   typedef enum logic [1:0] {
      HS_NONE  = 2'b00,
      HS_DATA  = 2'b01,
      HS_NAK   = 2'b10,
      HS_STALL = 2'b11
   } hs_code_e;
endpackage

// File: rtl/usb_in_hs_decide.sv
module usb_in_hs_decide
   import usb_in_hs_pkg::*;
#(
   parameter int NUM_EP  = 16,
   parameter int CTRL_EP = 0,
   localparam int EP_W   = $clog2(NUM_EP)
) (
   input  logic              tok_valid,
   input  logic [EP_W-1:0]   tok_ep,
   input  logic              req_err,
   input  logic              tx_ready,
   input  logic [NUM_EP-1:0] halt_vec,
   input  logic [NUM_EP-1:0] pend_vec,
   output hs_code_e          hs_next,
   output logic [NUM_EP-1:0] rec_nak,
   output logic [NUM_EP-1:0] rec_stall
);
   logic in_range;

   // A full power-of-two range needs no bound check
   generate
      if (NUM_EP == (1 << EP_W)) begin : g_full
         assign in_range = tok_valid;
      end else begin : g_partial
         assign in_range = tok_valid && (int'(tok_ep) < NUM_EP);
      end
   endgenerate

   logic halted, pending, ctrl_err;

   always_comb begin
      halted    = halt_vec[tok_ep];
      pending   = pend_vec[tok_ep];
      ctrl_err  = req_err && (tok_ep == EP_W'(CTRL_EP));
      hs_next   = HS_NONE;
      rec_nak   = '0;
      rec_stall = '0;
      if (in_range) begin
         if (halted || ctrl_err)
            hs_next = HS_STALL;
         else if (pending || !tx_ready)
            hs_next = HS_NAK;
         else
            hs_next = HS_DATA;
         if (!pending) begin
            if (hs_next == HS_STALL)
               rec_stall[tok_ep] = 1'b1;
            else if (hs_next == HS_NAK)
               rec_nak[tok_ep] = 1'b1;
         end
      end
   end
endmodule

// File: rtl/usb_in_ep_sel.sv
module usb_in_ep_sel #(
   parameter int NUM_EP = 16,
   localparam int EP_W  = $clog2(NUM_EP)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              sel_en,
   input  logic              sel_dir,
   input  logic [EP_W-1:0]   sel_ep,
   input  logic              set_halt,
   input  logic              clr_halt,
   output logic              sel_in,
   output logic [NUM_EP-1:0] halt_on,
   output logic [NUM_EP-1:0] halt_off,
   output logic [NUM_EP-1:0] release_vec
);
   logic            sel_in_q;
   logic [EP_W-1:0] sel_ep_q;
   logic            rel;

   assign sel_in = sel_en && sel_dir;
   assign rel    = sel_in_q && !sel_en;

   always_ff @(posedge clk) begin
      if (rst) begin
         sel_in_q <= 1'b0;
         sel_ep_q <= '0;
      end else begin
         sel_in_q <= sel_in;
         sel_ep_q <= sel_ep;
      end
   end

   generate
      for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
         logic hit_now, hit_prev;
         assign hit_now        = sel_in && (sel_ep == EP_W'(i));
         assign hit_prev       = sel_ep_q == EP_W'(i);
         assign halt_off[i]    = hit_now && clr_halt;
         assign halt_on[i]     = hit_now && set_halt && !clr_halt;
         assign release_vec[i] = rel && hit_prev;
      end
   endgenerate
endmodule

// File: rtl/usb_in_ep_slot.sv
module usb_in_ep_slot (
   input  logic clk,
   input  logic rst,
   input  logic halt_on,
   input  logic halt_off,
   input  logic release_st,
   input  logic rec_nak,
   input  logic rec_stall,
   input  logic irq_clr,
   output logic halt,
   output logic nak,
   output logic stall,
   output logic irq
);
   always_ff @(posedge clk) begin
      if (rst) begin
         halt  <= 1'b0;
         nak   <= 1'b0;
         stall <= 1'b0;
         irq   <= 1'b0;
      end else begin
         if (halt_off)
            halt <= 1'b0;
         else if (halt_on)
            halt <= 1'b1;
         if (rec_nak)
            nak <= 1'b1;
         else if (release_st)
            nak <= 1'b0;
         if (rec_stall)
            stall <= 1'b1;
         else if (release_st)
            stall <= 1'b0;
         if (rec_nak || rec_stall)
            irq <= 1'b1;
         else if (irq_clr)
            irq <= 1'b0;
      end
   end
endmodule

// File: rtl/usb_in_hs_ctrl.sv
module usb_in_hs_ctrl
   import usb_in_hs_pkg::*;
#(
   parameter int NUM_EP  = 16,
   parameter int CTRL_EP = 0,
   localparam int EP_W   = $clog2(NUM_EP)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tok_valid,
   input  logic [EP_W-1:0]   tok_ep,
   input  logic              req_err,
   input  logic              tx_ready,
   input  logic              sel_en,
   input  logic              sel_dir,
   input  logic [EP_W-1:0]   sel_ep,
   input  logic              set_halt,
   input  logic              clr_halt,
   input  logic [NUM_EP-1:0] irq_clr,
   output logic [1:0]        hs_code,
   output logic              sel_nak,
   output logic              sel_stall,
   output logic              sel_halt,
   output logic [NUM_EP-1:0] irq,
   output logic              irq_any
);
   generate
      if (NUM_EP < 2) begin : g_bad_num
         $error("NUM_EP must be at least 2");
      end
      if (CTRL_EP < 0 || CTRL_EP >= NUM_EP) begin : g_bad_ctrl
         $error("CTRL_EP must index an existing endpoint");
      end
   endgenerate

   logic [NUM_EP-1:0] halt_vec, nak_vec, stall_vec, pend_vec;
   logic [NUM_EP-1:0] rec_nak, rec_stall;
   logic [NUM_EP-1:0] halt_on, halt_off, release_vec;
   logic              sel_in;
   hs_code_e          hs_next, hs_q;

   assign pend_vec = nak_vec | stall_vec;

   usb_in_hs_decide #(.NUM_EP(NUM_EP), .CTRL_EP(CTRL_EP)) u_decide (
      .tok_valid (tok_valid),
      .tok_ep    (tok_ep),
      .req_err   (req_err),
      .tx_ready  (tx_ready),
      .halt_vec  (halt_vec),
      .pend_vec  (pend_vec),
      .hs_next   (hs_next),
      .rec_nak   (rec_nak),
      .rec_stall (rec_stall)
   );

   usb_in_ep_sel #(.NUM_EP(NUM_EP)) u_sel (
      .clk         (clk),
      .rst         (rst),
      .sel_en      (sel_en),
      .sel_dir     (sel_dir),
      .sel_ep      (sel_ep),
      .set_halt    (set_halt),
      .clr_halt    (clr_halt),
      .sel_in      (sel_in),
      .halt_on     (halt_on),
      .halt_off    (halt_off),
      .release_vec (release_vec)
   );

   generate
      for (genvar i = 0; i < NUM_EP; i++) begin : g_slot
         usb_in_ep_slot u_slot (
            .clk        (clk),
            .rst        (rst),
            .halt_on    (halt_on[i]),
            .halt_off   (halt_off[i]),
            .release_st (release_vec[i]),
            .rec_nak    (rec_nak[i]),
            .rec_stall  (rec_stall[i]),
            .irq_clr    (irq_clr[i]),
            .halt       (halt_vec[i]),
            .nak        (nak_vec[i]),
            .stall      (stall_vec[i]),
            .irq        (irq[i])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)
         hs_q <= HS_NONE;
      else
         hs_q <= hs_next;
   end

   assign hs_code   = hs_q;
   assign sel_nak   = sel_in && nak_vec[sel_ep];
   assign sel_stall = sel_in && stall_vec[sel_ep];
   assign sel_halt  = sel_in && halt_vec[sel_ep];
   assign irq_any   = |irq;
endmodule

// File: rtl/usb_in_hs_chk.sv
module usb_in_hs_chk #(
   parameter int NUM_EP  = 16,
   parameter int CTRL_EP = 0,
   localparam int EP_W   = $clog2(NUM_EP)
) (
   input logic              clk,
   input logic              rst,
   input logic              tok_valid,
   input logic [EP_W-1:0]   tok_ep,
   input logic              req_err,
   input logic              tx_ready,
   input logic [1:0]        hs_code,
   input logic [NUM_EP-1:0] irq,
   input logic [NUM_EP-1:0] halt_vec,
   input logic [NUM_EP-1:0] nak_vec,
   input logic [NUM_EP-1:0] stall_vec
);
   logic tok_ok, ctrl_err, pend;
   assign tok_ok   = tok_valid && (int'({1'b0, tok_ep}) < NUM_EP);
   assign ctrl_err = req_err && (int'({1'b0, tok_ep}) == CTRL_EP);
   assign pend     = nak_vec[tok_ep] || stall_vec[tok_ep];

   assert_stall_on_halt_R1: assert property (@(posedge clk) disable iff (rst)
      tok_ok && halt_vec[tok_ep] |=> hs_code == 2'b11);

   assert_stall_on_req_err_R2: assert property (@(posedge clk) disable iff (rst)
      tok_ok && ctrl_err |=> hs_code == 2'b11);

   assert_nak_no_data_R3: assert property (@(posedge clk) disable iff (rst)
      tok_ok && !halt_vec[tok_ep] && !ctrl_err && !tx_ready |=> hs_code == 2'b10);

   assert_irq_on_record_R4: assert property (@(posedge clk) disable iff (rst)
      tok_ok && !pend && (halt_vec[tok_ep] || ctrl_err || !tx_ready)
      |=> irq[$past(tok_ep)]);

   assert_hold_off_nak_R8: assert property (@(posedge clk) disable iff (rst)
      tok_ok && pend && !halt_vec[tok_ep] && !ctrl_err |=> hs_code == 2'b10);

   assert_idle_none_R9: assert property (@(posedge clk) disable iff (rst)
      !tok_valid |=> hs_code == 2'b00);

   assert_reset_clear_R11: assert property (@(posedge clk)
      rst |=> (hs_code == 2'b00 && irq == '0 && halt_vec == '0));

   generate
      for (genvar i = 0; i < NUM_EP; i++) begin : g_one
         assert_single_status_R7: assert property (@(posedge clk) disable iff (rst)
            $onehot0({nak_vec[i], stall_vec[i]}));
      end
   endgenerate
endmodule

bind usb_in_hs_ctrl usb_in_hs_chk #(.NUM_EP(NUM_EP), .CTRL_EP(CTRL_EP)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .tok_valid (tok_valid),
   .tok_ep    (tok_ep),
   .req_err   (req_err),
   .tx_ready  (tx_ready),
   .hs_code   (hs_code),
   .irq       (irq),
   .halt_vec  (halt_vec),
   .nak_vec   (nak_vec),
   .stall_vec (stall_vec)
);

// File: tb/usb_in_hs_ctrl_bench.sv
module usb_in_hs_ctrl_bench;
   localparam int CLK_P  = 10;
   localparam int NUM_EP = 16;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        tok_valid = 0, req_err = 0, tx_ready = 0;
   logic [3:0]  tok_ep = 0, sel_ep = 0;
   logic        sel_en = 0, sel_dir = 0, set_halt = 0, clr_halt = 0;
   logic [15:0] irq_clr = 0;
   logic [1:0]  hs_code;
   logic        sel_nak, sel_stall, sel_halt, irq_any;
   logic [15:0] irq;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #(CLK_P/2) clk = ~clk;

   usb_in_hs_ctrl #(.NUM_EP(NUM_EP), .CTRL_EP(0)) u_usb_in_hs_ctrl (
      .clk(clk), .rst(rst), .tok_valid(tok_valid), .tok_ep(tok_ep),
      .req_err(req_err), .tx_ready(tx_ready), .sel_en(sel_en),
      .sel_dir(sel_dir), .sel_ep(sel_ep), .set_halt(set_halt),
      .clr_halt(clr_halt), .irq_clr(irq_clr), .hs_code(hs_code),
      .sel_nak(sel_nak), .sel_stall(sel_stall), .sel_halt(sel_halt),
      .irq(irq), .irq_any(irq_any)
   );

   // Behavioural reference model
   logic [15:0] m_halt, m_nak, m_stall, m_irq, rn, rs;
   int          m_hs, e;
   bit          m_selq, pend, stl;
   logic [3:0]  m_selep;
   string       m_tag;

   always @(posedge clk) begin
      if (rst) begin
         m_halt = '0; m_nak = '0; m_stall = '0; m_irq = '0;
         m_hs = 0; m_selq = 0; m_selep = 0; m_tag = "R11";
      end else begin
         rn = '0; rs = '0;
         if (tok_valid) begin
            e    = int'(tok_ep);
            pend = m_nak[e] || m_stall[e];
            stl  = m_halt[e] || (e == 0 && req_err);
            if (stl) begin
               m_hs = 3; m_tag = m_halt[e] ? "R1" : "R2";
            end else if (pend) begin
               m_hs = 2; m_tag = "R8";
            end else if (!tx_ready) begin
               m_hs = 2; m_tag = "R3";
            end else begin
               m_hs = 1; m_tag = "R9";
            end
            if (!pend && m_hs == 3) rs[e] = 1'b1;
            if (!pend && m_hs == 2) rn[e] = 1'b1;
         end else begin
            m_hs = 0; m_tag = "R9";
         end
         if (m_selq && !sel_en) begin
            m_nak[m_selep] = 1'b0;
            m_stall[m_selep] = 1'b0;
         end
         m_nak   = m_nak | rn;
         m_stall = m_stall | rs;
         m_irq   = (m_irq & ~irq_clr) | rn | rs;
         if (sel_en && sel_dir && clr_halt) m_halt[sel_ep] = 1'b0;
         else if (sel_en && sel_dir && set_halt) m_halt[sel_ep] = 1'b1;
         m_selq  = sel_en && sel_dir;
         m_selep = sel_ep;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step();
      bit si;
      @(negedge clk);
      si = sel_en && sel_dir;
      chk(m_tag, 32'(hs_code), 32'(m_hs));
      chk("R4 irq", 32'(irq), 32'(m_irq));
      chk("R5 irq_any", 32'(irq_any), 32'(m_irq != 0));
      chk("R6 sel_nak", 32'(sel_nak), 32'(si && m_nak[sel_ep]));
      chk("R6 sel_stall", 32'(sel_stall), 32'(si && m_stall[sel_ep]));
      chk("R10 sel_halt", 32'(sel_halt), 32'(si && m_halt[sel_ep]));
   endtask

   task automatic tok(input int ep, input bit rdy, input bit err);
      tok_valid = 1; tok_ep = 4'(ep); tx_ready = rdy; req_err = err;
      step();
      tok_valid = 0; req_err = 0; tx_ready = 0;
   endtask

   task automatic sel(input int ep, input bit dir, input bit en);
      sel_ep = 4'(ep); sel_dir = dir; sel_en = en;
      step();
   endtask

   task automatic halt_cmd(input bit s, input bit c);
      set_halt = s; clr_halt = c;
      step();
      set_halt = 0; clr_halt = 0;
   endtask

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   logic [31:0] lfsr = 32'h1ACE_B00C;

   initial begin
      repeat (3) step();
      rst = 0;
      step();
      chk("R11 hs after reset", 32'(hs_code), 0);
      chk("R11 irq after reset", 32'(irq), 0);

      tok(3, 1, 0);  chk("R9 data", 32'(hs_code), 1);
      chk("R9 no irq on data", 32'(irq[3]), 0);
      tok(5, 0, 0);  chk("R3 nak", 32'(hs_code), 2);
      chk("R4 irq on nak", 32'(irq[5]), 1);
      sel(5, 1, 1);  chk("R6 read nak", 32'(sel_nak), 1);
      chk("R6 read stall", 32'(sel_stall), 0);
      tok(5, 1, 0);  chk("R8 hold-off nak", 32'(hs_code), 2);
      chk("R8 status kept", 32'({sel_nak, sel_stall}), 2);
      sel(5, 1, 0);
      sel(5, 1, 1);  chk("R7 released", 32'(sel_nak), 0);
      sel(5, 1, 0);
      tok(5, 1, 0);  chk("R7 data after release", 32'(hs_code), 1);
      irq_clr = 16'h0020; step(); irq_clr = 0;
      chk("R5 w1c", 32'(irq[5]), 0);

      tok(6, 0, 0);
      sel(6, 0, 1);  chk("R6 out dir hides", 32'(sel_nak), 0);
      sel(6, 1, 1);  chk("R6 in dir shows", 32'(sel_nak), 1);
      sel(6, 1, 0);

      sel(2, 1, 1);  halt_cmd(1, 0);
      chk("R10 set halt", 32'(sel_halt), 1);
      sel(2, 1, 0);
      tok(2, 1, 0);  chk("R1 stall", 32'(hs_code), 3);
      chk("R4 irq on stall", 32'(irq[2]), 1);
      sel(2, 1, 1);  chk("R4 stall bit", 32'(sel_stall), 1);
      sel(2, 1, 0);
      tok(2, 1, 0);  chk("R1 stall persists", 32'(hs_code), 3);
      sel(2, 1, 1);  halt_cmd(1, 1);
      chk("R10 clear wins", 32'(sel_halt), 0);
      sel(2, 1, 0);
      tok(2, 1, 0);  chk("R1 data after clear", 32'(hs_code), 1);

      sel(4, 0, 1);  halt_cmd(1, 0);  sel(4, 0, 0);
      tok(4, 1, 0);  chk("R10 out dir ignored", 32'(hs_code), 1);

      tok(0, 1, 1);  chk("R2 ctrl stall", 32'(hs_code), 3);
      tok(7, 1, 1);  chk("R2 non-ctrl ignores", 32'(hs_code), 1);
      sel(0, 1, 1);  chk("R2 stall bit", 32'(sel_stall), 1);
      sel(0, 1, 0);

      irq_clr = 16'h0200; tok(9, 0, 0); irq_clr = 0;
      chk("R5 set beats clear", 32'(irq[9]), 1);

      sel(1, 1, 1);  halt_cmd(1, 0);  sel(1, 1, 0);
      rst = 1; step(); step(); rst = 0;
      sel(1, 1, 1);  chk("R11 halt cleared", 32'(sel_halt), 0);
      chk("R11 irq cleared", 32'(irq), 0);
      sel(1, 1, 0);

      for (int n = 0; n < 3000; n++) begin
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         tok_valid = lfsr[0] | lfsr[1];
         tok_ep    = lfsr[5:2];
         tx_ready  = lfsr[6] | lfsr[7];
         req_err   = lfsr[8] & lfsr[9] & lfsr[10];
         if (lfsr[11] & lfsr[12]) sel_en = ~sel_en;
         if (!sel_en) begin
            sel_ep  = lfsr[16:13];
            sel_dir = lfsr[17] | lfsr[18];
         end
         set_halt = lfsr[19] & lfsr[20] & lfsr[21];
         clr_halt = lfsr[22] & lfsr[23] & lfsr[24];
         irq_clr  = (lfsr[25] & lfsr[26]) ? lfsr[31:16] : 16'h0;
         step();
      end
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule